// File: doc/BRIEF.md
# History-Based Branch Target Predictor

This block predicts the direction and destination of a conditional branch at instruction fetch. A table of 512 entries is addressed by the low bits of the branch address and confirmed by comparing the remaining high bits against a stored tag. Each entry holds the last known destination, a four-bit record of that branch's recent outcomes, and sixteen two-bit saturating counters. The recorded outcomes select which counter supplies the prediction. Because the record is kept per branch, a branch with a short repeating pattern, such as strict alternation, is learned and then predicted correctly.

When the table holds no entry for the address, the block predicts from the sign of the branch displacement. Backward branches, which are usually loop closers, are predicted taken. Forward branches are predicted not taken. The fallback destination is the address plus the displacement.

Resolved branches are written back through a single update port. An update to a branch not in the table claims the entry. Lookup is combinational. Updates take effect on the clock edge.

Top module: `bp_history_predictor`

## Requirements
- R1: After the asynchronous active-low reset, every entry is invalid, so `pred_hit_o` is 0 for every lookup address until an update is written.
- R2: An entry is selected by `lk_pc_i[8:0]`. It hits only when it is valid and its stored tag equals `lk_pc_i[31:9]`. Two addresses with the same low bits and different high bits never hit on each other's entry, and an update from one replaces the other.
- R3: On a miss, `pred_taken_o` equals bit 15 of `lk_disp_i`: a negative two's-complement displacement predicts taken, and zero or positive predicts not taken. `pred_target_o` is `lk_pc_i` plus the sign-extended displacement.
- R4: An update that misses allocates the entry at that address. It writes the new tag and target, clears the history to 0000, and sets all sixteen counters to weakly not taken. The next lookup of that address hits, predicts not taken, and returns the written target.
- R5: Counter encoding: 0 is strongly not taken, 1 is weakly not taken, 2 is weakly taken, 3 is strongly taken. An update that hits moves the counter selected by the entry's history one step up on a taken outcome and one step down otherwise, saturating at 0 and 3.
- R6: On a hit, `pred_taken_o` is 1 exactly when the counter selected by the entry's current history is 2 or 3.
- R7: Every update that hits shifts the outcome into the history at bit 0 (1 = taken), discarding bit 3. The counter used for a later prediction is the one indexed by the shifted history.
- R8: A branch updated with strictly alternating outcomes is predicted correctly on every lookup once it has had about a dozen updates.
- R9: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.
- R10: An update that hits overwrites the stored target with `upd_target_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | 32 | Address of the branch being looked up |
| lk_disp_i | input | 16 | Signed displacement of the branch being looked up, used on a miss |
| pred_hit_o | output | 1 | Lookup found a matching valid entry |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_target_o | output | 32 | Predicted destination address |
| upd_valid_i | input | 1 | Resolved-branch update strobe |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_target_i | input | 32 | Resolved destination address |

## Verification
All three outputs follow the lookup inputs combinationally, and they reflect every update written at or before the previous rising edge. The bench therefore drives stimulus on the falling edge and samples 5 ns later, before the next rising edge. It advances its reference model only at that rising edge, so an update issued in a given cycle first shows in the following cycle. The same-cycle case is checked against the old contents. Hand-derived checks on allocation, saturation, history selection and alternation sit beside the model comparison made on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] n;
    n = c;
    if (taken && c != CTR_ST) n = c + 2'd1;
    else if (!taken && c != CTR_SNT) n = c - 2'd1;
    return n;
  endfunction

  function automatic logic ctr_is_taken(input logic [1:0] c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp_static_fallback.sv
module bp_static_fallback #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 16
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  // backward branch -> taken
  assign taken_o  = disp_i[DISP_W-1];
  assign target_o = pc_i + disp_ext;
endmodule

// File: rtl/bp_tag_store.sv
module bp_tag_store #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 9,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [PC_W-IDX_W-1:0] rd_tag_i,
  output logic              rd_hit_o,
  output logic [PC_W-1:0]   rd_target_o,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  input  logic [PC_W-IDX_W-1:0] up_tag_i,
  output logic              up_hit_o,
  output logic [HIST_W-1:0] up_hist_o,
  input  logic              wr_en_i,
  input  logic              wr_alloc_i,
  input  logic [PC_W-1:0]   wr_target_i,
  input  logic              wr_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q  [ENTRIES];
  logic [HIST_W-1:0]  hist_q [ENTRIES];
  logic [HIST_W-1:0]  hist_nxt;

  assign rd_hit_o    = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_target_o = tgt_q[rd_idx_i];
  assign rd_hist_o   = hist_q[rd_idx_i];

  assign up_hit_o  = valid_q[up_idx_i] && (tag_q[up_idx_i] == up_tag_i);
  assign up_hist_o = hist_q[up_idx_i];

  assign hist_nxt = wr_alloc_i ? '0 : {up_hist_o[HIST_W-2:0], wr_taken_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[up_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[up_idx_i]  <= up_tag_i;
      tgt_q[up_idx_i]  <= wr_target_i;
      hist_q[up_idx_i] <= hist_nxt;
    end
  end
endmodule

// File: rtl/bp_pattern_store.sv
module bp_pattern_store
  import bp_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [HIST_W-1:0] rd_hist_i,
  output logic [1:0]        rd_ctr_o,
  input  logic              wr_en_i,
  input  logic              wr_alloc_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [HIST_W-1:0] wr_hist_i,
  input  logic              wr_taken_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PAT_N   = 1 << HIST_W;
  localparam int ROW_W   = 2 * PAT_N;

  logic [ROW_W-1:0] pat_q [ENTRIES];
  logic [ROW_W-1:0] rd_row;
  logic [ROW_W-1:0] wr_old;
  logic [ROW_W-1:0] wr_new;

  assign rd_row   = pat_q[rd_idx_i];
  assign rd_ctr_o = rd_row[2*rd_hist_i +: 2];
  assign wr_old   = pat_q[wr_idx_i];

  for (genvar g = 0; g < PAT_N; g++) begin : g_slot
    logic sel;
    assign sel = (wr_hist_i == HIST_W'(g));
    assign wr_new[2*g +: 2] = wr_alloc_i ? 2'(CTR_WNT)
                            : sel        ? ctr_step(wr_old[2*g +: 2], wr_taken_i)
                            :              wr_old[2*g +: 2];
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) pat_q[wr_idx_i] <= wr_new;
  end
endmodule

// File: rtl/bp_history_predictor.sv
module bp_history_predictor
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 9,
  parameter int HIST_W = 4,
  parameter int DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic [DISP_W-1:0] lk_disp_i,
  output logic              pred_hit_o,
  output logic              pred_taken_o,
  output logic [PC_W-1:0]   pred_target_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [PC_W-1:0]   upd_target_i
);
  localparam int TAG_W = PC_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              lk_hit, up_hit;
  logic [PC_W-1:0]   lk_tgt;
  logic [HIST_W-1:0] lk_hist, up_hist;
  logic [1:0]        lk_ctr;
  logic              fb_taken;
  logic [PC_W-1:0]   fb_target;

  assign lk_idx = lk_pc_i[IDX_W-1:0];
  assign lk_tag = lk_pc_i[PC_W-1:IDX_W];
  assign up_idx = upd_pc_i[IDX_W-1:0];
  assign up_tag = upd_pc_i[PC_W-1:IDX_W];

  bp_tag_store #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) i_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (lk_idx),
    .rd_tag_i    (lk_tag),
    .rd_hit_o    (lk_hit),
    .rd_target_o (lk_tgt),
    .rd_hist_o   (lk_hist),
    .up_idx_i    (up_idx),
    .up_tag_i    (up_tag),
    .up_hit_o    (up_hit),
    .up_hist_o   (up_hist),
    .wr_en_i     (upd_valid_i),
    .wr_alloc_i  (!up_hit),
    .wr_target_i (upd_target_i),
    .wr_taken_i  (upd_taken_i)
  );

  bp_pattern_store #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_pat (
    .clk_i      (clk_i),
    .rd_idx_i   (lk_idx),
    .rd_hist_i  (lk_hist),
    .rd_ctr_o   (lk_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_alloc_i (!up_hit),
    .wr_idx_i   (up_idx),
    .wr_hist_i  (up_hist),
    .wr_taken_i (upd_taken_i)
  );

  bp_static_fallback #(.PC_W(PC_W), .DISP_W(DISP_W)) i_fb (
    .pc_i     (lk_pc_i),
    .disp_i   (lk_disp_i),
    .taken_o  (fb_taken),
    .target_o (fb_target)
  );

  assign pred_hit_o    = lk_hit;
  assign pred_taken_o  = lk_hit ? ctr_is_taken(lk_ctr) : fb_taken;
  assign pred_target_o = lk_hit ? lk_tgt : fb_target;
endmodule

// File: rtl/bp_history_predictor_chk.sv
module bp_history_predictor_chk #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   lk_pc_i,
  input logic [DISP_W-1:0] lk_disp_i,
  input logic              pred_hit_o,
  input logic              pred_taken_o,
  input logic [PC_W-1:0]   pred_target_o,
  input logic              upd_valid_i,
  input logic [PC_W-1:0]   upd_pc_i,
  input logic [PC_W-1:0]   upd_target_i,
  input logic [1:0]        lk_ctr_i
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else live_q <= 1'b1;
  end

  // R1: nothing hits before the first post-reset edge
  a_r1_empty_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> !pred_hit_o);

  // R3: direction from displacement sign on a miss
  a_r3_miss_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> pred_taken_o == lk_disp_i[DISP_W-1]);

  // R3: fallback target
  a_r3_miss_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> pred_target_o ==
      lk_pc_i + {{(PC_W-DISP_W){lk_disp_i[DISP_W-1]}}, lk_disp_i});

  // R4 / R10: an updated branch hits with its written target next cycle
  a_r4_update_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && upd_valid_i) |=>
      (lk_pc_i != $past(upd_pc_i) || (pred_hit_o && pred_target_o == $past(upd_target_i))));

  // R6: taken counter states give a taken prediction on a hit
  a_r6_hit_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_hit_o |-> pred_taken_o == (lk_ctr_i >= 2'd2));
endmodule

bind bp_history_predictor bp_history_predictor_chk #(.PC_W(PC_W), .DISP_W(DISP_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_pc_i       (lk_pc_i),
  .lk_disp_i     (lk_disp_i),
  .pred_hit_o    (pred_hit_o),
  .pred_taken_o  (pred_taken_o),
  .pred_target_o (pred_target_o),
  .upd_valid_i   (upd_valid_i),
  .upd_pc_i      (upd_pc_i),
  .upd_target_i  (upd_target_i),
  .lk_ctr_i      (lk_ctr)
);

// File: tb/test_bp_history_predictor.sv
module test_bp_history_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [15:0] lk_disp = '0;
  logic        hit, taken;
  logic [31:0] target;
  logic        uv = 1'b0, ut = 1'b0;
  logic [31:0] upc = '0, utgt = '0;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  logic        s_hit, s_taken;
  logic [31:0] s_tgt;

  // behavioural reference
  bit          m_valid [512];
  int unsigned m_tag   [512];
  int unsigned m_tgt   [512];
  int          m_hist  [512];
  int          m_ctr   [512][16];

  always #10 clk = ~clk;

  bp_history_predictor i_bp_history_predictor (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_disp_i(lk_disp),
    .pred_hit_o(hit), .pred_taken_o(taken), .pred_target_o(target),
    .upd_valid_i(uv), .upd_pc_i(upc), .upd_taken_i(ut), .upd_target_i(utgt));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_lookup(input logic [31:0] pc, input logic [15:0] d,
                              output bit h, output bit t, output logic [31:0] tg);
    int i;
    i = int'(pc % 512);
    h = m_valid[i] && m_tag[i] == pc / 512;
    if (h) begin
      t  = m_ctr[i][m_hist[i]] >= 2;
      tg = m_tgt[i];
    end else begin
      t  = d[15];
      tg = pc + {{16{d[15]}}, d};
    end
  endtask

  task automatic model_update(input logic [31:0] pc, input bit t, input logic [31:0] tg);
    int i;
    i = int'(pc % 512);
    if (m_valid[i] && m_tag[i] == pc / 512) begin
      if (t && m_ctr[i][m_hist[i]] < 3) m_ctr[i][m_hist[i]]++;
      if (!t && m_ctr[i][m_hist[i]] > 0) m_ctr[i][m_hist[i]]--;
      m_hist[i] = ((m_hist[i] * 2) + (t ? 1 : 0)) % 16;
    end else begin
      m_valid[i] = 1'b1;
      m_tag[i]   = pc / 512;
      m_hist[i]  = 0;
      for (int k = 0; k < 16; k++) m_ctr[i][k] = 1;
    end
    m_tgt[i] = tg;
  endtask

  task automatic step(input logic [31:0] pc, input logic [15:0] d, input bit v,
                      input logic [31:0] up, input bit t, input logic [31:0] tg);
    bit eh, et;
    logic [31:0] etg;
    lk_pc = pc; lk_disp = d; uv = v; upc = up; ut = t; utgt = tg;
    #5;
    model_lookup(pc, d, eh, et, etg);
    s_hit = hit; s_taken = taken; s_tgt = target;
    chk(hit == eh, cur_req, "hit", 32'(hit), 32'(eh));
    chk(taken == et, cur_req, "taken", 32'(taken), 32'(et));
    chk(target == etg, cur_req, "target", target, etg);
    @(posedge clk);
    if (rst_n && v) model_update(up, t, tg);
    @(negedge clk);
    uv = 1'b0;
  endtask

  localparam logic [31:0] P0 = 32'h0000_1040;
  localparam logic [31:0] P1 = 32'h0000_2084;
  localparam logic [31:0] P2 = 32'h0000_30c8;
  localparam logic [31:0] P3 = P0 + 32'h200;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) m_valid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    cur_req = "R1";
    step(P0, 16'h0010, 0, '0, 0, '0);
    chk(!s_hit, "R1", "hit after reset", 32'(s_hit), 0);
    step(32'hffff_fe00, 16'h0000, 0, '0, 0, '0);
    chk(!s_hit, "R1", "hit after reset", 32'(s_hit), 0);

    // R3: fallback by displacement sign
    cur_req = "R3";
    step(P1, 16'hfff0, 0, '0, 0, '0);
    chk(s_taken == 1'b1, "R3", "backward taken", 32'(s_taken), 1);
    chk(s_tgt == P1 - 32'h10, "R3", "backward target", s_tgt, P1 - 32'h10);
    step(P1, 16'h0020, 0, '0, 0, '0);
    chk(s_taken == 1'b0, "R3", "forward not taken", 32'(s_taken), 0);
    step(P1, 16'h0000, 0, '0, 0, '0);
    chk(s_taken == 1'b0, "R3", "zero disp not taken", 32'(s_taken), 0);

    // R4: allocation
    cur_req = "R4";
    step(P1, 16'h0000, 1, P0, 1, 32'h0000_5000);
    step(P0, 16'hffff, 0, '0, 0, '0);
    chk(s_hit, "R4", "hit after alloc", 32'(s_hit), 1);
    chk(!s_taken, "R4", "weakly not taken after alloc", 32'(s_taken), 0);
    chk(s_tgt == 32'h0000_5000, "R4", "alloc target", s_tgt, 32'h0000_5000);

    // R9: same-cycle lookup sees old contents
    cur_req = "R9";
    step(P1, 16'hfffc, 1, P1, 1, 32'h0000_6000);
    chk(!s_hit, "R9", "same-cycle hit", 32'(s_hit), 0);
    chk(s_taken, "R9", "same-cycle fallback", 32'(s_taken), 1);
    step(P1, 16'hfffc, 0, '0, 0, '0);
    chk(s_hit, "R9", "hit next cycle", 32'(s_hit), 1);

    // R5 / R6 / R7: saturation and history selection on P0
    cur_req = "R5";
    for (int k = 0; k < 8; k++) step(P2, 16'h0004, 1, P0, 1, 32'h0000_5000);
    step(P0, 16'h0000, 0, '0, 0, '0);
    chk(s_taken, "R6", "saturated taken at hist 1111", 32'(s_taken), 1);
    cur_req = "R7";
    step(P2, 16'h0004, 1, P0, 0, 32'h0000_5000);
    step(P0, 16'h0000, 0, '0, 0, '0);
    chk(!s_taken, "R7", "fresh slot at hist 1110", 32'(s_taken), 0);
    step(P2, 16'h0004, 1, P0, 1, 32'h0000_5000);

    // R8: alternation
    cur_req = "R8";
    step(P2, 16'h0004, 1, P2, 0, 32'h0000_7000);
    for (int i = 0; i < 24; i++) begin
      step(P2, 16'h0004, 1, P2, (i % 2) == 0, 32'h0000_7000);
      if (i >= 16) chk(s_taken == ((i % 2) == 0), "R8", "alternation",
                       32'(s_taken), 32'((i % 2) == 0));
    end

    // R2: aliasing on index
    cur_req = "R2";
    step(P3, 16'h0004, 0, '0, 0, '0);
    chk(!s_hit, "R2", "alias miss", 32'(s_hit), 0);
    step(P3, 16'h0004, 1, P3, 1, 32'h0000_8000);
    step(P0, 16'h0004, 0, '0, 0, '0);
    chk(!s_hit, "R2", "evicted miss", 32'(s_hit), 0);

    // R10: target overwrite on hit
    cur_req = "R10";
    step(P3, 16'h0004, 1, P3, 1, 32'h0000_9000);
    step(P3, 16'h0004, 0, '0, 0, '0);
    chk(s_tgt == 32'h0000_9000, "R10", "target overwrite", s_tgt, 32'h0000_9000);

    // mixed traffic against the model
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pool [5];
      pool = '{P0, P1, P2, P3, 32'h0001_1040};
      step(pool[$urandom % 5], 16'($urandom), 1'($urandom),
           pool[$urandom % 5], 1'($urandom), $urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule